// File: doc/BRIEF.md
# Set-Associative Translation Buffer with Access Permission Check

This block caches recent virtual-to-physical page translations inside a memory management unit. A request carries a 32-bit virtual address and an access kind (read, write or execute). The upper 20 address bits form the virtual page number. Its two lowest bits select one of four sets, and its upper 18 bits form the tag that is compared against the four ways of that set. On a match the cached physical page number replaces the virtual page number, the 12-bit page offset passes through unchanged, and the stored permission bits are tested against the access kind. A match whose permissions refuse the access reports a protection fault and no address. No match reports a miss, so a page table walker can fetch the mapping and write it through the fill port. A flush input clears every entry when the address space changes.

The result is held in a small state register, `rsp_q`, with four states. RSP_IDLE means no request was made in the previous cycle. RSP_HIT means the translation is valid and is on `rsp_paddr`. RSP_MISS means no valid entry matched. RSP_FAULT means an entry matched but refused the access. Each clock edge takes the register to a new state, chosen from the request presented in that cycle. With no request the transition is "no request" and goes to RSP_IDLE. A request with no match is "lookup miss" and goes to RSP_MISS. A request that matches and is allowed is "lookup allowed" and goes to RSP_HIT. A request that matches but is refused is "lookup refused" and goes to RSP_FAULT. No state is sticky.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid and all response outputs are 0. The first lookup after reset reports a miss.
- R2: `rsp_valid` is high exactly in the cycle after `lkp_valid` is high. When `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is high. When it is low, all three are low.
- R3: On a hit, `rsp_paddr` equals {stored physical page number, `lkp_vaddr[11:0]`}. The set index is `lkp_vaddr[13:12]` and the tag is `lkp_vaddr[31:14]`.
- R4: `fill_perm` bit 0 allows read, bit 1 allows write and bit 2 allows execute. `lkp_kind` is 0 for read, 1 for write, 2 for execute, and 3, which no entry ever allows. A matching entry that lacks the requested permission produces `rsp_fault` with `rsp_paddr` equal to 0.
- R5: A lookup with no valid entry of equal tag in the indexed set reports `rsp_miss` with `rsp_paddr` equal to 0.
- R6: A fill writes the set selected by `fill_vpn[1:0]` and stores the tag `fill_vpn[19:2]`. It takes the lowest-numbered invalid way first.
- R7: When all four ways of a set are valid, a per-set round-robin pointer chooses the victim. The pointer starts at way 0 after reset and advances by one after each such eviction. Fills to one set never evict entries of another set.
- R8: A fill whose virtual page number is already valid in its set overwrites that entry in place. It evicts nothing and leaves the pointer unchanged.
- R9: `flush` invalidates every entry, so every later lookup misses until new fills arrive.
- R10: When `flush` and `fill_valid` are high in the same cycle, the flush wins and the filled entry is not valid afterwards.
- R11: A lookup in the same cycle as a fill or a flush sees the contents from before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_vaddr | input | 32 | Virtual address to translate |
| lkp_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| fill_valid | input | 1 | Write a translation this cycle |
| fill_vpn | input | 20 | Virtual page number of the new translation |
| fill_ppn | input | 12 | Physical page number of the new translation |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate all entries |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_hit | output | 1 | Translation allowed, address valid |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Matching entry refuses the access |
| rsp_paddr | output | 24 | Physical address on hit, else 0 |

## Verification
On every cycle the assertions check the following properties, which need no knowledge of the stored contents:
- the one-cycle response timing and the one-hot result encoding;
- the page offset carried through on hits, and a zero address on misses and faults;
- that access kind 3 never hits;
- that a lookup in the cycle after a flush misses.

The directed scenarios cover the behaviours that depend on what the entries hold:
- permission outcomes for each access kind;
- invalid-way-first placement and the order of round-robin eviction;
- in-place refill and isolation between sets;
- a flush that wins over a fill in the same cycle;
- lookups that see the contents from before a same-cycle update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_MISS  = 2'd2,
        RSP_FAULT = 2'd3
    } rsp_e;

    localparam int PERM_W  = 3;
    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_EX = 2;
endpackage

// File: rtl/tlb_set_match.sv
module tlb_set_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 18,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            valid_i,
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAYS-1:0] eq;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tags_i[g] == tag_i);
    end

    assign hit_o = |eq;

    always_comb begin
        way_o = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) way_o = WAY_W'(w);
        end
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic             found_i,
    input  logic [WAY_W-1:0] found_way_i,
    input  logic [WAY_W-1:0] rr_i,
    output logic [WAY_W-1:0] way_o,
    output logic             advance_o
);
    logic [WAY_W-1:0] free_way;

    always_comb begin
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) free_way = WAY_W'(w);
        end
    end

    always_comb begin
        advance_o = 1'b0;
        if (found_i) begin
            way_o = found_way_i;
        end else if (!(&valid_i)) begin
            way_o = free_way;
        end else begin
            way_o     = rr_i;
            advance_o = 1'b1;
        end
    end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 24,
    parameter int OFS_W = 12,
    parameter int SETS  = 4,
    parameter int WAYS  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lkp_valid,
    input  logic [VA_W-1:0]         lkp_vaddr,
    input  logic [1:0]              lkp_kind,
    input  logic                    fill_valid,
    input  logic [VA_W-OFS_W-1:0]   fill_vpn,
    input  logic [PA_W-OFS_W-1:0]   fill_ppn,
    input  logic [PERM_W-1:0]       fill_perm,
    input  logic                    flush,
    output logic                    rsp_valid,
    output logic                    rsp_hit,
    output logic                    rsp_miss,
    output logic                    rsp_fault,
    output logic [PA_W-1:0]         rsp_paddr
);
    localparam int VPN_W = VA_W - OFS_W;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int WAY_W = $clog2(WAYS);

    // Entry storage
    logic [SETS-1:0][WAYS-1:0]             valid_q;
    logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag_q;
    logic [SETS-1:0][WAYS-1:0][PPN_W-1:0]  ppn_q;
    logic [SETS-1:0][WAYS-1:0][PERM_W-1:0] perm_q;
    logic [SETS-1:0][WAY_W-1:0]            rr_q;

    // Lookup path
    logic [IDX_W-1:0]  lk_idx;
    logic [TAG_W-1:0]  lk_tag;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [PPN_W-1:0]  lk_ppn;
    logic [PERM_W-1:0] lk_perm;
    logic              perm_ok;

    assign lk_idx  = lkp_vaddr[OFS_W +: IDX_W];
    assign lk_tag  = lkp_vaddr[VA_W-1 -: TAG_W];

    tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
        .valid_i (valid_q[lk_idx]),
        .tags_i  (tag_q[lk_idx]),
        .tag_i   (lk_tag),
        .hit_o   (lk_hit),
        .way_o   (lk_way)
    );

    assign lk_ppn  = ppn_q[lk_idx][lk_way];
    assign lk_perm = perm_q[lk_idx][lk_way];

    always_comb begin
        unique case (acc_e'(lkp_kind))
            ACC_READ:  perm_ok = lk_perm[PERM_RD];
            ACC_WRITE: perm_ok = lk_perm[PERM_WR];
            ACC_EXEC:  perm_ok = lk_perm[PERM_EX];
            ACC_NONE:  perm_ok = 1'b0;
        endcase
    end

    // Fill path
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;
    logic             fl_hit;
    logic [WAY_W-1:0] fl_way;
    logic [WAY_W-1:0] fl_victim;
    logic             fl_adv;

    assign fl_idx = fill_vpn[IDX_W-1:0];
    assign fl_tag = fill_vpn[VPN_W-1 -: TAG_W];

    tlb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
        .valid_i (valid_q[fl_idx]),
        .tags_i  (tag_q[fl_idx]),
        .tag_i   (fl_tag),
        .hit_o   (fl_hit),
        .way_o   (fl_way)
    );

    tlb_victim #(.WAYS(WAYS)) u_victim (
        .valid_i     (valid_q[fl_idx]),
        .found_i     (fl_hit),
        .found_way_i (fl_way),
        .rr_i        (rr_q[fl_idx]),
        .way_o       (fl_victim),
        .advance_o   (fl_adv)
    );

    // Valid bits and replacement pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            rr_q    <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (fill_valid) begin
            valid_q[fl_idx][fl_victim] <= 1'b1;
            if (fl_adv) rr_q[fl_idx] <= rr_q[fl_idx] + 1'b1;
        end
    end

    // Entry payload, meaningful only under a valid bit
    always_ff @(posedge clk) begin
        if (fill_valid) begin
            tag_q[fl_idx][fl_victim]  <= fl_tag;
            ppn_q[fl_idx][fl_victim]  <= fill_ppn;
            perm_q[fl_idx][fl_victim] <= fill_perm;
        end
    end

    // Result state machine
    rsp_e            rsp_q, rsp_d;
    logic [PA_W-1:0] paddr_q, paddr_d;

    always_comb begin
        if (!lkp_valid)     rsp_d = RSP_IDLE;
        else if (!lk_hit)   rsp_d = RSP_MISS;
        else if (perm_ok)   rsp_d = RSP_HIT;
        else                rsp_d = RSP_FAULT;
        paddr_d = (rsp_d == RSP_HIT) ? {lk_ppn, lkp_vaddr[OFS_W-1:0]} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q   <= RSP_IDLE;
            paddr_q <= '0;
        end else begin
            rsp_q   <= rsp_d;
            paddr_q <= paddr_d;
        end
    end

    always_comb begin
        rsp_valid = 1'b1;
        rsp_hit   = 1'b0;
        rsp_miss  = 1'b0;
        rsp_fault = 1'b0;
        unique case (rsp_q)
            RSP_IDLE:  rsp_valid = 1'b0;
            RSP_HIT:   rsp_hit   = 1'b1;
            RSP_MISS:  rsp_miss  = 1'b1;
            RSP_FAULT: rsp_fault = 1'b1;
        endcase
        rsp_paddr = paddr_q;
    end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
    parameter int PA_W  = 24,
    parameter int OFS_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lkp_valid,
    input logic [OFS_W-1:0] lkp_ofs,
    input logic [1:0]       lkp_kind,
    input logic             flush,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic             rsp_miss,
    input logic             rsp_fault,
    input logic [PA_W-1:0]  rsp_paddr
);
    p_one_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 1);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_fault}) == 0);

    p_resp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);

    p_offset_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(lkp_ofs)));

    p_fault_no_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> rsp_paddr == '0);

    p_kind_none_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && lkp_kind == 2'd3) |=> !rsp_hit);

    p_miss_no_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> rsp_paddr == '0);

    p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && $past(flush)) |=> rsp_miss);
endmodule

bind tlb_xlate tlb_xlate_chk #(.PA_W(PA_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_ofs   (lkp_vaddr[OFS_W-1:0]),
    .lkp_kind  (lkp_kind),
    .flush     (flush),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_miss  (rsp_miss),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr)
);

// File: tb/tlb_xlate_bench.sv
`timescale 1ns/1ps
module tlb_xlate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [31:0] lkp_vaddr = '0;
    logic [1:0]  lkp_kind = '0;
    logic        fill_valid = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [11:0] fill_ppn = '0;
    logic [2:0]  fill_perm = '0;
    logic        flush = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
    logic [23:0] rsp_paddr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    tlb_xlate u_tlb_xlate (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_vaddr(lkp_vaddr), .lkp_kind(lkp_kind),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_perm(fill_perm), .flush(flush),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_EX = 2'd2, K_NO = 2'd3;

    function automatic logic [31:0] va(input logic [17:0] tag, input logic [1:0] idx,
                                       input logic [11:0] ofs);
        return {tag, idx, ofs};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Status packed as {valid, hit, miss, fault}
    function automatic logic [3:0] st();
        return {rsp_valid, rsp_hit, rsp_miss, rsp_fault};
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [17:0] tag, input logic [1:0] idx,
                           input logic [11:0] ppn, input logic [2:0] perm);
        fill_valid = 1'b1; fill_vpn = {tag, idx}; fill_ppn = ppn; fill_perm = perm;
        tick();
        fill_valid = 1'b0;
    endtask

    task automatic do_lookup(input logic [31:0] a, input logic [1:0] k);
        lkp_valid = 1'b1; lkp_vaddr = a; lkp_kind = k;
        tick();
        lkp_valid = 1'b0;
    endtask

    task automatic exp_hit(input string req, input logic [31:0] a, input logic [1:0] k,
                           input logic [11:0] ppn);
        do_lookup(a, k);
        check(req, {28'd0, st()}, 32'b1100);
        check(req, {8'd0, rsp_paddr}, {8'd0, ppn, a[11:0]});
    endtask

    task automatic exp_miss(input string req, input logic [31:0] a, input logic [1:0] k);
        do_lookup(a, k);
        check(req, {28'd0, st()}, 32'b1010);
        check(req, {8'd0, rsp_paddr}, 32'd0);
    endtask

    task automatic exp_fault(input string req, input logic [31:0] a, input logic [1:0] k);
        do_lookup(a, k);
        check(req, {28'd0, st()}, 32'b1001);
        check(req, {8'd0, rsp_paddr}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 idle outputs", {4'd0, st(), rsp_paddr}, 32'd0);
        exp_miss("R1 first lookup", va(18'h00123, 2'd0, 12'h000), K_RD);
        tick();
        check("R2 no request idle", {28'd0, st()}, 32'd0);
    endtask

    task automatic t_basic();
        do_fill(18'h00123, 2'd0, 12'hA5C, 3'b011);
        exp_hit("R3 read hit", va(18'h00123, 2'd0, 12'h7F3), K_RD, 12'hA5C);
        exp_hit("R3 write hit", va(18'h00123, 2'd0, 12'h000), K_WR, 12'hA5C);
        exp_fault("R4 exec refused", va(18'h00123, 2'd0, 12'h010), K_EX);
        exp_fault("R4 kind3 refused", va(18'h00123, 2'd0, 12'h010), K_NO);
        exp_miss("R5 other set", va(18'h00123, 2'd2, 12'h010), K_RD);
        exp_miss("R5 other tag", va(18'h00124, 2'd0, 12'h010), K_RD);
    endtask

    task automatic t_exec_only();
        do_fill(18'h2AAAA, 2'd3, 12'h3C1, 3'b100);
        exp_fault("R4 read on exec-only", va(18'h2AAAA, 2'd3, 12'h444), K_RD);
        exp_fault("R4 write on exec-only", va(18'h2AAAA, 2'd3, 12'h444), K_WR);
        exp_hit("R4 exec on exec-only", va(18'h2AAAA, 2'd3, 12'hFFF), K_EX, 12'h3C1);
    endtask

    task automatic t_replace();
        for (int i = 0; i < 4; i++) do_fill(18'h10 + 18'(i), 2'd1, 12'h100 + 12'(i), 3'b111);
        for (int i = 0; i < 4; i++)
            exp_hit("R6 fill free ways", va(18'h10 + 18'(i), 2'd1, 12'h0AB), K_RD, 12'h100 + 12'(i));
        do_fill(18'h14, 2'd1, 12'h104, 3'b111);
        exp_miss("R7 way0 evicted", va(18'h10, 2'd1, 12'h0), K_RD);
        exp_hit("R7 new entry", va(18'h14, 2'd1, 12'h1), K_RD, 12'h104);
        exp_hit("R7 way1 kept", va(18'h11, 2'd1, 12'h2), K_RD, 12'h101);
        do_fill(18'h15, 2'd1, 12'h105, 3'b111);
        exp_miss("R7 way1 evicted", va(18'h11, 2'd1, 12'h0), K_RD);
        exp_hit("R7 way2 kept", va(18'h12, 2'd1, 12'h3), K_RD, 12'h102);
        exp_hit("R7 other set kept", va(18'h2AAAA, 2'd3, 12'h5), K_EX, 12'h3C1);
        do_fill(18'h12, 2'd1, 12'h7EE, 3'b111);
        exp_hit("R8 refill new ppn", va(18'h12, 2'd1, 12'h9), K_RD, 12'h7EE);
        exp_hit("R8 no evict a", va(18'h13, 2'd1, 12'h9), K_RD, 12'h103);
        exp_hit("R8 no evict b", va(18'h14, 2'd1, 12'h9), K_RD, 12'h104);
        exp_hit("R8 no evict c", va(18'h15, 2'd1, 12'h9), K_RD, 12'h105);
    endtask

    task automatic t_same_cycle_fill();
        fill_valid = 1'b1; fill_vpn = {18'h0BEEF, 2'd2}; fill_ppn = 12'h555; fill_perm = 3'b001;
        lkp_valid = 1'b1; lkp_vaddr = va(18'h0BEEF, 2'd2, 12'h321); lkp_kind = K_RD;
        tick();
        fill_valid = 1'b0; lkp_valid = 1'b0;
        check("R11 lookup before fill", {28'd0, st()}, 32'b1010);
        exp_hit("R11 lookup after fill", va(18'h0BEEF, 2'd2, 12'h321), K_RD, 12'h555);
    endtask

    task automatic t_flush();
        flush = 1'b1; lkp_valid = 1'b1; lkp_vaddr = va(18'h0BEEF, 2'd2, 12'h1); lkp_kind = K_RD;
        tick();
        flush = 1'b0; lkp_valid = 1'b0;
        check("R11 lookup with flush", {28'd0, st()}, 32'b1100);
        exp_miss("R9 set2 gone", va(18'h0BEEF, 2'd2, 12'h1), K_RD);
        exp_miss("R9 set1 gone", va(18'h13, 2'd1, 12'h1), K_RD);
        exp_miss("R9 set3 gone", va(18'h2AAAA, 2'd3, 12'h1), K_EX);
        flush = 1'b1; fill_valid = 1'b1; fill_vpn = {18'h00777, 2'd0};
        fill_ppn = 12'h777; fill_perm = 3'b111;
        tick();
        flush = 1'b0; fill_valid = 1'b0;
        exp_miss("R10 flush beats fill", va(18'h00777, 2'd0, 12'h2), K_RD);
        do_fill(18'h00777, 2'd0, 12'h778, 3'b111);
        exp_hit("R9 refill after flush", va(18'h00777, 2'd0, 12'h2), K_WR, 12'h778);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_exec_only();
        t_replace();
        t_same_cycle_fill();
        t_flush();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule